// File: doc/BRIEF.md
# OTP Word Lock and Debug-Enable Register File

This block keeps the lock state that guards a one-time-programmable fuse array and its shadow copy. Each fuse word has three separate lock flags: one that blocks reloading the word's shadow from the fuses, one that blocks software writes to the shadow, and one that blocks burning the fuse. Software can only set these flags. They clear only on reset. A fourth, read-only flag set is captured from the fuse array and marks words that are locked for good. A small global lock register holds three sticky bits. One freezes the upper region of words. One freezes the debug-enable register. One blocks all programming.

Every shadow or fuse operation first presents its kind and word number to the block. One cycle later the block answers with a grant, a refusal with an error, or, for a locked shadow write, a silent discard. The debug-enable register drives an 11-bit vector of debug enables to the rest of the chip.

Top module: `otp_lock_regfile`

## Requirements
- R1: After reset every lock bank, the global lock register and the debug-enable register read 0, and `dbg_en_o` is 0.
- R2: The reload, shadow-write and program lock banks live at byte offsets 0x94, 0x7C and 0x64. Bank k is at base+4k, and word ID maps to bank ID>>5, bit ID&31. A write ORs the data into the bank, so a 0 bit leaves its lock unchanged.
- R3: The global lock register at 0x10 holds write-one-to-set, sticky bits: bit 0 is the upper-region lock, bit 2 is the debug lock and bit 4 is the program lock. All other bits read 0.
- R4: A write to the debug-enable register at 0x14 reads back as the data masked to bits 10:0 and appears on `dbg_en_o` from the next cycle.
- R5: While the debug lock (0x10 bit 2) is set, writes to 0x14 are ignored and the frozen value stays on both the read data and `dbg_en_o`.
- R6: The permanent-lock banks at 0x4C (same bank/bit mapping) load from `fuse_lock_i` when `fuse_load_i` is pulsed. Bus writes to them are ignored.
- R7: `op_kind_i` is coded 0 = shadow reload, 1 = shadow write, 2 = program, 3 = reserved. Each cycle with `op_valid_i` high gets exactly one response on the next cycle: `rsp_valid_o`=1 with at most one of `rsp_ok_o` and `rsp_err_o` set.
- R8: A reload of a word whose reload lock is set is refused (ok=0, err=1). Otherwise it is granted.
- R9: A shadow write to a word whose write lock is set is discarded (ok=0, err=0). Otherwise it is granted.
- R10: A program request is refused with an error if the word's program lock or permanent lock is set, or if the global program lock is set.
- R11: While the upper-region lock is set, requests for words at or above UPPER_BASE (32) are blocked: reload and program are refused with an error, and a shadow write is discarded. Lower words are unaffected.
- R12: A lock write and an operation on the same word in the same cycle: the operation is judged on the lock state from before the write, and later operations see the new lock.
- R13: An operation for a word number at or above NUM_WORDS (96), or with the reserved kind, is refused with an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 12 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i` (combinational) |
| fuse_load_i | input | 1 | Capture strobe for the permanent-lock flags |
| fuse_lock_i | input | NUM_WORDS | Permanent-lock flags from the fuse array |
| op_valid_i | input | 1 | Operation request |
| op_kind_i | input | 2 | Operation kind |
| op_word_i | input | clog2(NUM_WORDS) | Word number of the operation |
| rsp_valid_o | output | 1 | Response valid, one cycle after the request |
| rsp_ok_o | output | 1 | Operation granted |
| rsp_err_o | output | 1 | Operation refused with error |
| dbg_en_o | output | DBG_W | Debug enable vector |

## Verification
The register bus and the operation port are independent, so a lock can be set in the same cycle that an operation names the same word. The bench provokes this by driving a shadow-write lock on word 20 together with a shadow write to word 20 on one clock edge. The scoreboard expects that write to be granted and the next write to the word to be silently discarded. Back-to-back operations check that each request gets exactly one response, in order.

// File: rtl/otp_lock_pkg.sv
package otp_lock_pkg;
  localparam logic [11:0] GLOB_OFF = 12'h010;
  localparam logic [11:0] DBG_OFF  = 12'h014;
  localparam logic [11:0] PERM_OFF = 12'h04C;
  localparam logic [11:0] PROG_OFF = 12'h064;
  localparam logic [11:0] WLK_OFF  = 12'h07C;
  localparam logic [11:0] RLK_OFF  = 12'h094;

  localparam int unsigned GL_UPPER_BIT = 0;
  localparam int unsigned GL_DBG_BIT   = 2;
  localparam int unsigned GL_PROG_BIT  = 4;

  typedef enum logic [1:0] {
    OP_RELOAD  = 2'd0,
    OP_SWRITE  = 2'd1,
    OP_PROGRAM = 2'd2,
    OP_RSVD    = 2'd3
  } op_kind_e;
endpackage

// File: rtl/otp_lock_bitmap.sv
module otp_lock_bitmap #(
  parameter int unsigned NUM_WORDS = 96,
  parameter logic [11:0] BASE      = 12'h000,
  parameter bit          FROM_FUSE = 1'b0
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic [11:0]          addr_i,
  input  logic [31:0]          wdata_i,
  input  logic                 load_i,
  input  logic [NUM_WORDS-1:0] fuse_i,
  output logic [NUM_WORDS-1:0] bits_o,
  output logic [31:0]          rdata_o
);
  localparam int unsigned BANKS = (NUM_WORDS + 31) / 32;
  localparam int unsigned PADW  = BANKS * 32;
  localparam logic [PADW-1:0] VMASK = PADW'({NUM_WORDS{1'b1}});

  logic [PADW-1:0] bits_q, bits_d;
  logic bus_wr, ld;
  logic unused_in;
  assign unused_in = ^{wr_en_i, load_i, fuse_i, wdata_i};

  always_comb begin
    bits_d  = bits_q;
    rdata_o = '0;
    for (int b = 0; b < BANKS; b++) begin
      if (addr_i == BASE + 12'(4 * b)) begin
        rdata_o = bits_q[b*32 +: 32];
        if (bus_wr) bits_d[b*32 +: 32] = bits_q[b*32 +: 32] | wdata_i;
      end
    end
    if (ld) bits_d = PADW'(fuse_i);
    bits_d = bits_d & VMASK;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bits_q <= '0;
    else         bits_q <= bits_d;
  end

  assign bits_o = bits_q[NUM_WORDS-1:0];

  if (FROM_FUSE) begin : g_fuse
    assign bus_wr = 1'b0;
    assign ld     = load_i;
    // R6
    fuse_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$past(load_i) |-> $stable(bits_q));
  end else begin : g_sw
    assign bus_wr = wr_en_i;
    assign ld     = 1'b0;
    // R2
    sticky_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(bits_q) & ~bits_q) == '0);
  end
endmodule

// File: rtl/otp_glob_ctrl.sv
module otp_glob_ctrl
  import otp_lock_pkg::*;
#(
  parameter int unsigned DBG_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [11:0]      addr_i,
  input  logic [31:0]      wdata_i,
  output logic             upper_lock_o,
  output logic             dbg_lock_o,
  output logic             prog_lock_o,
  output logic [DBG_W-1:0] dbg_en_o,
  output logic [31:0]      rdata_o
);
  logic upper_q, dbg_lock_q, prog_q;
  logic [DBG_W-1:0] dbg_q;
  logic glob_hit, dbg_hit;
  logic unused_wd;
  assign unused_wd = ^wdata_i;

  assign glob_hit = (addr_i == GLOB_OFF);
  assign dbg_hit  = (addr_i == DBG_OFF);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      upper_q    <= 1'b0;
      dbg_lock_q <= 1'b0;
      prog_q     <= 1'b0;
      dbg_q      <= '0;
    end else begin
      if (wr_en_i && glob_hit) begin
        upper_q    <= upper_q    | wdata_i[GL_UPPER_BIT];
        dbg_lock_q <= dbg_lock_q | wdata_i[GL_DBG_BIT];
        prog_q     <= prog_q     | wdata_i[GL_PROG_BIT];
      end
      if (wr_en_i && dbg_hit && !dbg_lock_q) dbg_q <= wdata_i[DBG_W-1:0];
    end
  end

  always_comb begin
    rdata_o = '0;
    if (glob_hit) begin
      rdata_o[GL_UPPER_BIT] = upper_q;
      rdata_o[GL_DBG_BIT]   = dbg_lock_q;
      rdata_o[GL_PROG_BIT]  = prog_q;
    end else if (dbg_hit) begin
      rdata_o[DBG_W-1:0] = dbg_q;
    end
  end

  assign upper_lock_o = upper_q;
  assign dbg_lock_o   = dbg_lock_q;
  assign prog_lock_o  = prog_q;
  assign dbg_en_o     = dbg_q;

  // R3
  glock_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past({upper_q, dbg_lock_q, prog_q}) & ~{upper_q, dbg_lock_q, prog_q}) == 3'b000);
  // R5
  dbg_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(dbg_lock_q) |-> $stable(dbg_q));
endmodule

// File: rtl/otp_op_gate.sv
module otp_op_gate
  import otp_lock_pkg::*;
#(
  parameter int unsigned NUM_WORDS  = 96,
  parameter int unsigned UPPER_BASE = 32,
  parameter int unsigned ID_W       = $clog2(NUM_WORDS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 op_valid_i,
  input  logic [1:0]           op_kind_i,
  input  logic [ID_W-1:0]      op_word_i,
  input  logic [NUM_WORDS-1:0] rlk_i,
  input  logic [NUM_WORDS-1:0] wlk_i,
  input  logic [NUM_WORDS-1:0] plk_i,
  input  logic [NUM_WORDS-1:0] perm_i,
  input  logic                 upper_lock_i,
  input  logic                 prog_lock_i,
  output logic                 rsp_valid_o,
  output logic                 rsp_ok_o,
  output logic                 rsp_err_o
);
  localparam int unsigned SPAN = 1 << ID_W;

  logic [SPAN-1:0] rlk_x, wlk_x, plk_x, perm_x;
  logic in_range, upper_blk, ok_d, err_d;
  logic valid_q, ok_q, err_q;

  assign rlk_x  = SPAN'(rlk_i);
  assign wlk_x  = SPAN'(wlk_i);
  assign plk_x  = SPAN'(plk_i);
  assign perm_x = SPAN'(perm_i);

  assign in_range  = ({1'b0, op_word_i} < (ID_W+1)'(NUM_WORDS));
  assign upper_blk = upper_lock_i && (op_word_i >= ID_W'(UPPER_BASE));

  always_comb begin
    ok_d  = 1'b0;
    err_d = 1'b1;
    if (in_range) begin
      unique case (op_kind_e'(op_kind_i))
        OP_RELOAD: begin
          err_d = rlk_x[op_word_i] || upper_blk;
          ok_d  = !err_d;
        end
        OP_SWRITE: begin
          err_d = 1'b0;
          ok_d  = !(wlk_x[op_word_i] || upper_blk);
        end
        OP_PROGRAM: begin
          err_d = plk_x[op_word_i] || perm_x[op_word_i] || prog_lock_i || upper_blk;
          ok_d  = !err_d;
        end
        default: begin
          err_d = 1'b1;
          ok_d  = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      ok_q    <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      valid_q <= op_valid_i;
      ok_q    <= op_valid_i && ok_d;
      err_q   <= op_valid_i && err_d;
    end
  end

  assign rsp_valid_o = valid_q;
  assign rsp_ok_o    = ok_q;
  assign rsp_err_o   = err_q;

  // R7
  rsp_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o == $past(op_valid_i));
  // R7
  rsp_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rsp_ok_o && rsp_err_o));
  // R7
  rsp_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rsp_valid_o |-> (!rsp_ok_o && !rsp_err_o));
endmodule

// File: rtl/otp_lock_regfile.sv
module otp_lock_regfile
  import otp_lock_pkg::*;
#(
  parameter int unsigned NUM_WORDS  = 96,
  parameter int unsigned UPPER_BASE = 32,
  parameter int unsigned DBG_W      = 11
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         reg_wr_i,
  input  logic [11:0]                  reg_addr_i,
  input  logic [31:0]                  reg_wdata_i,
  output logic [31:0]                  reg_rdata_o,
  input  logic                         fuse_load_i,
  input  logic [NUM_WORDS-1:0]         fuse_lock_i,
  input  logic                         op_valid_i,
  input  logic [1:0]                   op_kind_i,
  input  logic [$clog2(NUM_WORDS)-1:0] op_word_i,
  output logic                         rsp_valid_o,
  output logic                         rsp_ok_o,
  output logic                         rsp_err_o,
  output logic [DBG_W-1:0]             dbg_en_o
);
  localparam int unsigned ID_W = $clog2(NUM_WORDS);

  logic [NUM_WORDS-1:0] rlk, wlk, plk, perm;
  logic [31:0] rd_rlk, rd_wlk, rd_plk, rd_perm, rd_glob;
  logic upper_lock, dbg_lock, prog_lock;

  otp_lock_bitmap #(.NUM_WORDS(NUM_WORDS), .BASE(RLK_OFF), .FROM_FUSE(1'b0)) u_rlk (
    .clk_i, .rst_ni, .wr_en_i(reg_wr_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .load_i(fuse_load_i), .fuse_i(fuse_lock_i), .bits_o(rlk), .rdata_o(rd_rlk));

  otp_lock_bitmap #(.NUM_WORDS(NUM_WORDS), .BASE(WLK_OFF), .FROM_FUSE(1'b0)) u_wlk (
    .clk_i, .rst_ni, .wr_en_i(reg_wr_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .load_i(fuse_load_i), .fuse_i(fuse_lock_i), .bits_o(wlk), .rdata_o(rd_wlk));

  otp_lock_bitmap #(.NUM_WORDS(NUM_WORDS), .BASE(PROG_OFF), .FROM_FUSE(1'b0)) u_plk (
    .clk_i, .rst_ni, .wr_en_i(reg_wr_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .load_i(fuse_load_i), .fuse_i(fuse_lock_i), .bits_o(plk), .rdata_o(rd_plk));

  otp_lock_bitmap #(.NUM_WORDS(NUM_WORDS), .BASE(PERM_OFF), .FROM_FUSE(1'b1)) u_perm (
    .clk_i, .rst_ni, .wr_en_i(reg_wr_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .load_i(fuse_load_i), .fuse_i(fuse_lock_i), .bits_o(perm), .rdata_o(rd_perm));

  otp_glob_ctrl #(.DBG_W(DBG_W)) u_glob (
    .clk_i, .rst_ni, .wr_en_i(reg_wr_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .upper_lock_o(upper_lock), .dbg_lock_o(dbg_lock), .prog_lock_o(prog_lock),
    .dbg_en_o(dbg_en_o), .rdata_o(rd_glob));

  otp_op_gate #(.NUM_WORDS(NUM_WORDS), .UPPER_BASE(UPPER_BASE), .ID_W(ID_W)) u_gate (
    .clk_i, .rst_ni, .op_valid_i, .op_kind_i, .op_word_i,
    .rlk_i(rlk), .wlk_i(wlk), .plk_i(plk), .perm_i(perm),
    .upper_lock_i(upper_lock), .prog_lock_i(prog_lock),
    .rsp_valid_o, .rsp_ok_o, .rsp_err_o);

  assign reg_rdata_o = rd_rlk | rd_wlk | rd_plk | rd_perm | rd_glob;

  // R5
  dbg_out_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(dbg_lock) |-> $stable(dbg_en_o));
endmodule

// File: tb/otp_lock_regfile_tb_top.sv
module otp_lock_regfile_tb_top;
  localparam int unsigned NW = 96;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic reg_wr_i = 1'b0;
  logic [11:0] reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic fuse_load_i = 1'b0;
  logic [NW-1:0] fuse_lock_i = '0;
  logic op_valid_i = 1'b0;
  logic [1:0] op_kind_i = '0;
  logic [6:0] op_word_i = '0;
  logic rsp_valid_o, rsp_ok_o, rsp_err_o;
  logic [10:0] dbg_en_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [1:0] exp_q[$];
  string tag_q[$];

  always #5 clk_i = ~clk_i;

  otp_lock_regfile dut_i (
    .clk_i, .rst_ni, .reg_wr_i, .reg_addr_i, .reg_wdata_i, .reg_rdata_o,
    .fuse_load_i, .fuse_lock_i, .op_valid_i, .op_kind_i, .op_word_i,
    .rsp_valid_o, .rsp_ok_o, .rsp_err_o, .dbg_en_o);

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(string tag, logic [11:0] a, logic [31:0] exp);
    reg_addr_i = a;
    #1;
    check(tag, reg_rdata_o, exp);
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_wr_i = 1'b0;
  endtask

  // expected {ok,err}
  task automatic op(string tag, logic [1:0] k, logic [6:0] w, logic [1:0] exp);
    op_valid_i = 1'b1; op_kind_i = k; op_word_i = w;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk_i);
    op_valid_i = 1'b0;
  endtask

  task automatic drain();
    @(negedge clk_i);
    @(negedge clk_i);
  endtask

  // monitor
  always @(negedge clk_i) begin
    if (rst_ni && rsp_valid_o) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R7 unexpected response actual=%b%b expected=none", rsp_ok_o, rsp_err_o);
      end else begin
        logic [1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, {30'd0, rsp_ok_o, rsp_err_o}, {30'd0, e});
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    for (int b = 0; b < 3; b++) begin
      rd("R1 rlk", 12'h094 + 12'(4*b), 32'h0);
      rd("R1 wlk", 12'h07C + 12'(4*b), 32'h0);
      rd("R1 plk", 12'h064 + 12'(4*b), 32'h0);
      rd("R1 perm", 12'h04C + 12'(4*b), 32'h0);
    end
    rd("R1 glob", 12'h010, 32'h0);
    rd("R1 dbg", 12'h014, 32'h0);
    check("R1 dbg_en_o", 32'(dbg_en_o), 32'h0);
    check("R7 idle rsp", {31'd0, rsp_valid_o}, 32'h0);
    op("R8 reload free", 2'd0, 7'd3, 2'b10);

    // R2 sticky W1S on reload bank 1
    wr(12'h098, 32'h100);
    rd("R2 set bit", 12'h098, 32'h100);
    wr(12'h098, 32'h0);
    rd("R2 zero no effect", 12'h098, 32'h100);
    wr(12'h098, 32'h200);
    rd("R2 accumulate", 12'h098, 32'h300);
    op("R8 reload locked 40", 2'd0, 7'd40, 2'b01);
    op("R8 reload locked 41", 2'd0, 7'd41, 2'b01);
    op("R8 reload free 42", 2'd0, 7'd42, 2'b10);

    // R9 shadow write lock word 7
    wr(12'h07C, 32'h80);
    op("R9 write locked", 2'd1, 7'd7, 2'b00);
    op("R9 write free", 2'd1, 7'd8, 2'b10);

    // R12 same-cycle lock write and op on word 20
    reg_wr_i = 1'b1; reg_addr_i = 12'h07C; reg_wdata_i = 32'h0010_0000;
    op("R12 same cycle sees old", 2'd1, 7'd20, 2'b10);
    reg_wr_i = 1'b0;
    op("R12 next sees new", 2'd1, 7'd20, 2'b00);
    rd("R12 wlk bank0", 12'h07C, 32'h0010_0080);

    // R10 program lock word 65
    wr(12'h06C, 32'h2);
    rd("R2 prog bank2", 12'h06C, 32'h2);
    op("R10 prog locked", 2'd2, 7'd65, 2'b01);
    op("R10 prog free", 2'd2, 7'd66, 2'b10);

    // R6 permanent lock word 70
    fuse_lock_i[70] = 1'b1;
    fuse_load_i = 1'b1;
    @(negedge clk_i);
    fuse_load_i = 1'b0;
    rd("R6 perm loaded", 12'h054, 32'h40);
    wr(12'h054, 32'hFFFF_FFFF);
    rd("R6 perm bus write ignored", 12'h054, 32'h40);
    op("R10 prog perm locked", 2'd2, 7'd70, 2'b01);
    op("R10 reload perm word ok", 2'd0, 7'd70, 2'b10);

    // R4 debug enable
    wr(12'h014, 32'hFFFF_F5A5);
    rd("R4 dbg mask", 12'h014, 32'h5A5);
    check("R4 dbg_en_o", 32'(dbg_en_o), 32'h5A5);
    wr(12'h014, 32'h10);
    rd("R4 dbg rewrite", 12'h014, 32'h10);

    // R3 + R10 global program lock
    wr(12'h010, 32'h10);
    rd("R3 prog lock", 12'h010, 32'h10);
    op("R10 global prog lock", 2'd2, 7'd2, 2'b01);
    wr(12'h010, 32'h0A);
    rd("R3 zero/invalid bits", 12'h010, 32'h10);

    // R11 upper region
    op("R11 upper reload before", 2'd0, 7'd50, 2'b10);
    wr(12'h010, 32'h01);
    rd("R3 upper lock", 12'h010, 32'h11);
    op("R11 upper reload", 2'd0, 7'd50, 2'b01);
    op("R11 upper write", 2'd1, 7'd50, 2'b00);
    op("R11 lower reload", 2'd0, 7'd10, 2'b10);
    op("R11 lower write", 2'd1, 7'd10, 2'b10);
    op("R11 boundary 31", 2'd1, 7'd31, 2'b10);
    op("R11 boundary 32", 2'd1, 7'd32, 2'b00);

    // R5 debug lock
    wr(12'h010, 32'h04);
    rd("R3 debug lock", 12'h010, 32'h15);
    wr(12'h014, 32'h7FF);
    rd("R5 dbg frozen", 12'h014, 32'h10);
    check("R5 dbg_en_o frozen", 32'(dbg_en_o), 32'h10);

    // R13 out of range and reserved kind
    op("R13 word 100", 2'd0, 7'd100, 2'b01);
    op("R13 word 96 write", 2'd1, 7'd96, 2'b01);
    op("R13 reserved kind", 2'd3, 7'd0, 2'b01);

    drain();
    check("R7 all responses seen", 32'(exp_q.size()), 32'h0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule